// File: doc/BRIEF.md
# Paged Hardware-Monitor Register Window

This block gives a host a byte-wide window of 256 I/O offsets into a hardware-monitor function. Sixteen banks of byte storage share one offset range. A page register chooses which bank that range reaches. A write-control register carries a single commit flag. To change bank contents, the host drops the flag, writes the banked bytes, and raises the flag again. That rising edge is the only moment the monitor side learns of new data.

On the monitor side there is a one-cycle change-notify pulse and one decoded output: the power-supply fan PWM duty byte. That byte lives in bank 1 at offset 0x98. The duty output is loaded from storage only at the commit edge. Writes to that location while the flag is low stay invisible to the fan until the host commits. The host port is synchronous. Read data is registered and appears after the clock edge that samples the read strobe.

Top module: `hwmon_page_window`

## Requirements
- R1: After reset the page register is 0, the commit flag is 1, every bank byte is 0, the fan duty output is 0, the notify output is 0 and the read data is 0.
- R2: A read strobe at any offset, with the flag high or low, loads host_rdata at the next clock edge. Offset 0x04 reads as seven zero bits above the commit flag in bit 0.
- R3: A write to offsets 0x10 to 0xFE stores a byte in the selected bank only while the commit flag is 0. While the flag is 1, such a write leaves storage unchanged.
- R4: A write to offset 0xFF loads its low four bits into the page register. Bits 7:4 read back as zero. The next banked access after that write uses the new bank.
- R5: Each of the 16 banks holds its own bytes, so one offset in two banks keeps two separate values.
- R6: A write to 0x04 with bit 0 set while the flag is 0 raises mon_notify for exactly the one cycle after that edge. Writing bit 0 = 1 while the flag is already 1, or writing bit 0 = 0, gives no pulse.
- R7: mon_fan_duty takes the byte stored at bank 1, offset 0x98 on the commit edge of R6, and holds that value at every other time.
- R8: Offsets 0x00 to 0x03 and 0x05 to 0x0F read as zero, and writes to them change nothing.
- R9: When a read and a write hit the same offset in one cycle, the read returns the contents held before the write.
- R10: Bits 7:1 of a write to 0x04 are discarded, and they read back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Byte offset within the window |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| mon_notify | output | 1 | One-cycle pulse on commit |
| mon_fan_duty | output | 8 | Committed PSU fan PWM duty |

## Verification
The host port allows a read and a write in the same cycle. The interesting collision is both strobes aimed at one offset, either a banked byte or the page register. The bench raises host_rd and host_wr together at one offset. It expects the returned byte to be the value from before the write, and a later plain read to return the new value. The bench also checks that the duty byte seen by the fan tracks commits and not raw writes. It rewrites bank 1, offset 0x98 with the flag low and confirms the output holds until the flag rises.

// File: rtl/hwmon_win_pkg.sv
package hwmon_win_pkg;
    localparam logic [7:0] CTRL_OFF  = 8'h04;
    localparam logic [7:0] PAGE_OFF  = 8'hFF;
    localparam logic [7:0] BANK_LO   = 8'h10;
    localparam logic [7:0] BANK_HI   = 8'hFE;
    localparam logic [7:0] DUTY_OFF  = 8'h98;
    localparam int         DUTY_BANK = 1;
    localparam int         BANK_SPAN = int'(BANK_HI) - int'(BANK_LO) + 1;

    typedef struct packed {
        logic is_ctrl;
        logic is_page;
        logic is_bank;
    } addr_class_t;
endpackage

// File: rtl/hwmon_addr_decode.sv
module hwmon_addr_decode
    import hwmon_win_pkg::*;
(
    input  logic [7:0]  addr,
    output addr_class_t cls,
    output logic [7:0]  bank_idx
);
    always_comb begin
        cls.is_ctrl = (addr == CTRL_OFF);
        cls.is_page = (addr == PAGE_OFF);
        cls.is_bank = (addr >= BANK_LO) && (addr <= BANK_HI);
        bank_idx    = addr - BANK_LO;
    end
endmodule

// File: rtl/hwmon_bank_store.sv
module hwmon_bank_store
    import hwmon_win_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PAGE_W-1:0] page,
    input  logic [7:0]        idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] duty_tap
);
    localparam int NUM_BANKS = 1 << PAGE_W;
    localparam int DUTY_IDX  = int'(DUTY_OFF) - int'(BANK_LO);

    logic [DATA_W-1:0] mem_q [NUM_BANKS][BANK_SPAN];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                for (int i = 0; i < BANK_SPAN; i++) begin
                    mem_q[b][i] <= '0;
                end
            end
        end else if (we) begin
            mem_q[page][idx] <= wdata;
        end
    end

    always_comb begin
        rdata    = (int'(idx) < BANK_SPAN) ? mem_q[page][idx] : '0;
        duty_tap = mem_q[DUTY_BANK][DUTY_IDX];
    end
endmodule

// File: rtl/hwmon_commit_ctrl.sv
module hwmon_commit_ctrl
    import hwmon_win_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  addr_class_t       cls,
    input  logic [PAGE_W-1:0] wpage,
    input  logic              wflag,
    input  logic [DATA_W-1:0] duty_tap,
    output logic [PAGE_W-1:0] page,
    output logic              flag,
    output logic              notify,
    output logic [DATA_W-1:0] duty,
    output logic              bank_we
);
    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              flag;
        logic              notify;
        logic [DATA_W-1:0] duty;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.notify = 1'b0;
        if (wr && cls.is_page) begin
            st_d.page = wpage;
        end
        if (wr && cls.is_ctrl) begin
            st_d.flag = wflag;
            if (wflag && !st_q.flag) begin
                st_d.notify = 1'b1;
                st_d.duty   = duty_tap;
            end
        end
        bank_we = wr && cls.is_bank && !st_q.flag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.page   <= '0;
            st_q.flag   <= 1'b1;
            st_q.notify <= 1'b0;
            st_q.duty   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page   = st_q.page;
    assign flag   = st_q.flag;
    assign notify = st_q.notify;
    assign duty   = st_q.duty;
endmodule

// File: rtl/hwmon_page_window.sv
module hwmon_page_window
    import hwmon_win_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              mon_notify,
    output logic [DATA_W-1:0] mon_fan_duty
);
    addr_class_t       cls;
    logic [7:0]        bank_idx;
    logic [PAGE_W-1:0] page;
    logic              flag;
    logic              bank_we;
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] duty_tap;
    logic [DATA_W-1:0] rdata_d, rdata_q;

    hwmon_addr_decode dec_i (
        .addr     (host_addr),
        .cls      (cls),
        .bank_idx (bank_idx)
    );

    hwmon_bank_store #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bank_we),
        .page     (page),
        .idx      (bank_idx),
        .wdata    (host_wdata),
        .rdata    (mem_rdata),
        .duty_tap (duty_tap)
    );

    hwmon_commit_ctrl #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) ctl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (host_wr),
        .cls      (cls),
        .wpage    (host_wdata[PAGE_W-1:0]),
        .wflag    (host_wdata[0]),
        .duty_tap (duty_tap),
        .page     (page),
        .flag     (flag),
        .notify   (mon_notify),
        .duty     (mon_fan_duty),
        .bank_we  (bank_we)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (host_rd) begin
            if (cls.is_ctrl)      rdata_d = {{(DATA_W-1){1'b0}}, flag};
            else if (cls.is_page) rdata_d = {{(DATA_W-PAGE_W){1'b0}}, page};
            else if (cls.is_bank) rdata_d = mem_rdata;
            else                  rdata_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign host_rdata = rdata_q;
endmodule

// File: rtl/hwmon_page_window_chk.sv
module hwmon_page_window_chk
    import hwmon_win_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        host_addr,
    input logic              host_wr,
    input logic              host_rd,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic              mon_notify,
    input logic [DATA_W-1:0] mon_fan_duty
);
    // R6
    notify_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mon_notify |=> !mon_notify);

    // R6
    notify_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mon_notify |-> $past(host_wr && host_addr == CTRL_OFF && host_wdata[0]));

    // R7
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_notify |-> $stable(mon_fan_duty));

    // R4
    page_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_rd && host_addr == PAGE_OFF) |-> host_rdata[DATA_W-1:PAGE_W] == '0);

    // R10
    ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_rd && host_addr == CTRL_OFF) |-> host_rdata[DATA_W-1:1] == '0);

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_rd && host_addr < BANK_LO && host_addr != CTRL_OFF) |-> host_rdata == '0);
endmodule

bind hwmon_page_window hwmon_page_window_chk #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_addr    (host_addr),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .host_wdata   (host_wdata),
    .host_rdata   (host_rdata),
    .mon_notify   (mon_notify),
    .mon_fan_duty (mon_fan_duty)
);

// File: tb/hwmon_page_window_tb.sv
module hwmon_page_window_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       mon_notify;
    logic [7:0] mon_fan_duty;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    hwmon_page_window dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mon_notify(mon_notify), .mon_fan_duty(mon_fan_duty)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic rdwr(input logic [7:0] a, input logic [7:0] wd, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = wd; host_rd = 1'b1; host_wr = 1'b1;
        @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0;
        d = host_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 rdata", host_rdata, 8'h00);
        check("R1 notify", {7'b0, mon_notify}, 8'h00);
        check("R1 duty", mon_fan_duty, 8'h00);
        rd(8'h04, v); check("R1 flag", v, 8'h01);
        rd(8'hFF, v); check("R1 page", v, 8'h00);
        rd(8'h10, v); check("R1 storage", v, 8'h00);
    endtask

    task automatic t_lock();
        logic [7:0] v;
        wr(8'h20, 8'h55);
        rd(8'h20, v); check("R3 write ignored while flag set", v, 8'h00);
        wr(8'h04, 8'h00);
        rd(8'h04, v); check("R2 ctrl read while clear", v, 8'h00);
        wr(8'h20, 8'h55);
        rd(8'h20, v); check("R3 write accepted while clear", v, 8'h55);
    endtask

    task automatic t_pages();
        logic [7:0] v;
        wr(8'hFF, 8'hA3);
        rd(8'hFF, v); check("R4 page readback", v, 8'h03);
        wr(8'h20, 8'h66);
        rd(8'h20, v); check("R4 new page used at once", v, 8'h66);
        wr(8'hFF, 8'h00);
        rd(8'h20, v); check("R5 bank 0 kept", v, 8'h55);
        wr(8'hFF, 8'h03);
        rd(8'h20, v); check("R5 bank 3 kept", v, 8'h66);
    endtask

    task automatic t_commit();
        logic [7:0] v;
        wr(8'hFF, 8'h01);
        wr(8'h98, 8'h7C);
        check("R7 duty before commit", mon_fan_duty, 8'h00);
        check("R6 no pulse before commit", {7'b0, mon_notify}, 8'h00);
        wr(8'h04, 8'h01);
        check("R6 pulse on commit", {7'b0, mon_notify}, 8'h01);
        check("R7 duty on commit", mon_fan_duty, 8'h7C);
        @(negedge clk);
        check("R6 pulse one cycle", {7'b0, mon_notify}, 8'h00);
        wr(8'h04, 8'h01);
        check("R6 no pulse when already set", {7'b0, mon_notify}, 8'h00);
        wr(8'h04, 8'h00);
        check("R6 no pulse on clear", {7'b0, mon_notify}, 8'h00);
        wr(8'h98, 8'h20);
        @(negedge clk);
        check("R7 duty held while clear", mon_fan_duty, 8'h7C);
        wr(8'h04, 8'hFF);
        check("R7 duty on second commit", mon_fan_duty, 8'h20);
        rd(8'h04, v); check("R10 ctrl upper bits zero", v, 8'h01);
        wr(8'h04, 8'hFE);
        rd(8'h04, v); check("R10 bit0 clear with upper set", v, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr(8'h07, 8'hAA);
        rd(8'h07, v); check("R8 unmapped 0x07", v, 8'h00);
        wr(8'h00, 8'h5A);
        rd(8'h00, v); check("R8 unmapped 0x00", v, 8'h00);
        rd(8'h20, v); check("R8 bank untouched", v, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        rdwr(8'h30, 8'h11, v); check("R9 bank read old", v, 8'h00);
        rd(8'h30, v); check("R9 bank read new", v, 8'h11);
        rdwr(8'hFF, 8'h05, v); check("R9 page read old", v, 8'h01);
        rd(8'hFF, v); check("R9 page read new", v, 8'h05);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lock();
        t_pages();
        t_commit();
        t_unmapped();
        t_collide();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule